// File: doc/BRIEF.md
# B-Channel Slot Port for a 2B+D Serial Link

This block is the slave side of a 2B+D-style serial link. A master supplies a bit clock and a sync pulse that is one clock period wide. The port counts rising clock edges from the edge that samples the sync pulse and uses that count to find two 8-bit bearer slots. The first slot starts one edge after sync and the second starts eleven edges after sync. A channel-select input picks one of the two slots, and that slot is used in both directions.

In the chosen slot the port shifts out a parallel byte on rising edges, most significant bit first, and drives an output enable. On the falling edges of the same slot it gathers the receive line into a byte. When the slot closes it presents that byte with a one-cycle valid strobe. Outside the chosen slot the transmit line is not driven. This includes the whole slot of the other channel. A new sync restarts the count at any point. A byte that is only partly received when this happens is dropped.

Top module: `idl_bport`

## Requirements
- R1: While reset is asserted, txEn, txData, rxValid and rxByte are all 0.
- R2: After reset and before the first sync, txEn stays 0 and rxValid stays 0, whatever the other inputs do.
- R3: When chanSel was 0 (first channel) at the sync edge, txEn is 1 after rising edges 1 to 8 counted from the sync edge. After rising edge n, txData holds bit (8-n) of the byte latched at the sync edge, so the MSB goes out first.
- R4: When chanSel was 1 (second channel) at the sync edge, txEn is 1 after rising edges 11 to 18. After edge n, txData holds bit (18-n) of the latched byte.
- R5: On the falling edge that follows each rising edge of the chosen slot, rxData is shifted in, MSB first. On the falling edge of the slot's last bit, rxByte takes the assembled byte and rxValid is 1 until the next falling edge. At every other falling edge rxValid is 0.
- R6: After every rising edge that lies outside the chosen slot, txEn is 0 and txData is 0.
- R7: chanSel and txByte are captured only on the edge that samples syncIn. Changes to them during a frame have no effect on that frame.
- R8: A sync during a frame restarts the edge count on that edge and forces txEn to 0 after it. A partly received byte does not raise rxValid, and rxByte keeps its previous value.
- R9: The edge count saturates after edge 19. In a frame longer than 19 edges no further slot opens until the next sync.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock from the link master |
| rstN | input | 1 | Asynchronous reset, active low |
| syncIn | input | 1 | Frame sync, high for one clock period |
| chanSel | input | 1 | Slot choice: 0 = first channel, 1 = second channel |
| txByte | input | SLOT_BITS | Byte to send in the next frame |
| txData | output | 1 | Serial transmit data, 0 when not enabled |
| txEn | output | 1 | Transmit line output enable |
| rxData | input | 1 | Serial receive data |
| rxByte | output | SLOT_BITS | Last complete received byte |
| rxValid | output | 1 | One-cycle strobe marking a new rxByte |

## Verification
The bench builds the port with its default parameters: 8-bit slots that start at edges 1 and 11. With these values a 20-edge frame covers both slots and the gap between them. Frames of 40 edges take the counter into saturation, and a sync placed five edges into a frame cuts the first slot short. A behavioural model compares every rising and falling edge against the port. The stimulus covers both channel choices, mid-frame changes to the select and to the byte, and idle stretches before the first sync.

// File: rtl/idl_port_pkg.sv
package idl_port_pkg;
  timeunit 1ns;
  timeprecision 1ps;

  // Strobes passed from the slot control to the shifting datapath
  typedef struct packed {
    logic load;    // sync seen on this rising edge: capture the byte
    logic txStep;  // this rising edge drives a slot bit
    logic rxStep;  // coming falling edge samples a slot bit
    logic rxLast;  // that sample is the final bit of the slot
  } portStrobe_t;
endpackage

// File: rtl/idl_port_ctrl.sv
module idl_port_ctrl
  import idl_port_pkg::*;
#(
  parameter int SLOT_BITS = 8,
  parameter int B1_START  = 1,
  parameter int B2_START  = 11
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        syncIn,
  input  logic        chanSel,
  output portStrobe_t strobe,
  output logic        txEn
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int END1    = B1_START + SLOT_BITS - 1;
  localparam int END2    = B2_START + SLOT_BITS - 1;
  localparam int CNT_MAX = ((END1 > END2) ? END1 : END2) + 1;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(CNT_MAX);

  logic [CNT_W-1:0] edgeCnt;
  logic             selB2;
  logic [CNT_W:0]   nextPos;

  function automatic int slotStart(input logic b2);
    return b2 ? B2_START : B1_START;
  endfunction

  function automatic logic inSlot(input int pos, input logic b2);
    return (pos >= slotStart(b2)) && (pos < slotStart(b2) + SLOT_BITS);
  endfunction

  assign nextPos = {1'b0, edgeCnt} + 1'b1;

  always_comb begin
    strobe.load   = syncIn;
    strobe.txStep = !syncIn && inSlot(int'(nextPos), selB2);
    strobe.rxStep = inSlot(int'(edgeCnt), selB2);
    strobe.rxLast = strobe.rxStep &&
                    (int'(edgeCnt) == slotStart(selB2) + SLOT_BITS - 1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      edgeCnt <= CNT_TOP;
      selB2   <= 1'b0;
      txEn    <= 1'b0;
    end else if (syncIn) begin
      edgeCnt <= '0;
      selB2   <= chanSel;
      txEn    <= 1'b0;
    end else begin
      if (edgeCnt != CNT_TOP) edgeCnt <= edgeCnt + 1'b1;
      txEn <= strobe.txStep;
    end
  end

  // R8: a sync edge always leaves the line disabled
  assert_sync_drops_tx_R8: assert property (@(posedge clk) disable iff (!rstN)
    syncIn |=> !txEn);

  // R3 / R4: enable rises only on the first edge of the chosen slot
  assert_slot_start_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txEn) |-> (int'(edgeCnt) == slotStart(selB2)));

  // R6: enable falls right after the last bit of the slot
  assert_slot_end_R6: assert property (@(posedge clk) disable iff (!rstN)
    (txEn && !syncIn && int'(edgeCnt) == slotStart(selB2) + SLOT_BITS - 1)
      |=> !txEn);

  // R9: a saturated count stays put and opens no slot
  assert_count_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (edgeCnt == CNT_TOP && !syncIn) |=> (edgeCnt == CNT_TOP && !txEn));
endmodule

// File: rtl/idl_port_dp.sv
module idl_port_dp
  import idl_port_pkg::*;
#(
  parameter int SLOT_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  portStrobe_t          strobe,
  input  logic [SLOT_BITS-1:0] txByte,
  output logic                 txData,
  input  logic                 rxData,
  output logic [SLOT_BITS-1:0] rxByte,
  output logic                 rxValid
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int MSB = SLOT_BITS - 1;

  logic [MSB:0] txShift;
  logic [MSB:0] rxShift;
  logic [MSB:0] rxNext;

  assign rxNext = {rxShift[MSB-1:0], rxData};

  // Transmit side: rising edges
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '0;
      txData  <= 1'b0;
    end else if (strobe.load) begin
      txShift <= txByte;
      txData  <= 1'b0;
    end else if (strobe.txStep) begin
      txData  <= txShift[MSB];
      txShift <= {txShift[MSB-1:0], 1'b0};
    end else begin
      txData  <= 1'b0;
    end
  end

  // Receive side: falling edges
  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift <= '0;
      rxByte  <= '0;
      rxValid <= 1'b0;
    end else begin
      rxValid <= strobe.rxStep && strobe.rxLast;
      if (strobe.rxStep) rxShift <= rxNext;
      if (strobe.rxStep && strobe.rxLast) rxByte <= rxNext;
    end
  end

  // R5: the receive strobe lasts a single cycle
  assert_valid_pulse_R5: assert property (@(negedge clk) disable iff (!rstN)
    rxValid |=> !rxValid);
endmodule

// File: rtl/idl_bport.sv
module idl_bport
  import idl_port_pkg::*;
#(
  parameter int SLOT_BITS = 8,
  parameter int B1_START  = 1,
  parameter int B2_START  = 11
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 syncIn,
  input  logic                 chanSel,
  input  logic [SLOT_BITS-1:0] txByte,
  output logic                 txData,
  output logic                 txEn,
  input  logic                 rxData,
  output logic [SLOT_BITS-1:0] rxByte,
  output logic                 rxValid
);
  timeunit 1ns;
  timeprecision 1ps;

  portStrobe_t strobe;

  idl_port_ctrl #(
    .SLOT_BITS(SLOT_BITS), .B1_START(B1_START), .B2_START(B2_START)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .syncIn(syncIn), .chanSel(chanSel),
    .strobe(strobe), .txEn(txEn)
  );

  idl_port_dp #(.SLOT_BITS(SLOT_BITS)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .txByte(txByte),
    .txData(txData), .rxData(rxData), .rxByte(rxByte), .rxValid(rxValid)
  );

  // R6: an undriven line carries 0
  assert_idle_zero_R6: assert property (@(posedge clk) disable iff (!rstN)
    !txEn |-> !txData);
endmodule

// File: tb/sim_idl_bport.sv
module sim_idl_bport;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int SAT = 19;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic syncIn = 1'b0, chanSel = 1'b0, rxData = 1'b0;
  logic [7:0] txByte = 8'h00;
  logic txData, txEn, rxValid;
  logic [7:0] rxByte;

  int checks = 0, fails = 0;
  string tag = "R1";

  int edgeM = 1000;
  bit selM = 0;
  logic [7:0] byteM = 0, accM = 0, rxByteM = 0;

  always #2.5 clk = ~clk;

  idl_bport u0 (
    .clk(clk), .rstN(rstN), .syncIn(syncIn), .chanSel(chanSel),
    .txByte(txByte), .txData(txData), .txEn(txEn), .rxData(rxData),
    .rxByte(rxByte), .rxValid(rxValid)
  );

  task automatic chk(input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s at %0t: actual %0h expected %0h", tag, what, $time, act, exp);
    end
  endtask

  // one full clock: drive at the current point, model and compare both edges
  task automatic step(input bit s, input bit sel, input logic [7:0] b, input bit rb);
    int st;
    bit expEn, inSl;
    logic expD;
    syncIn = s; chanSel = sel; txByte = b;
    @(posedge clk);
    if (s) begin edgeM = 0; selM = sel; byteM = b; end
    else if (edgeM < SAT) edgeM++;
    #1 rxData = rb;
    st = selM ? 11 : 1;
    inSl = (edgeM >= st) && (edgeM < st + 8);
    expEn = !s && inSl;
    expD = expEn ? byteM[7 - (edgeM - st)] : 1'b0;
    chk("txEn", {7'b0, txEn}, {7'b0, expEn});
    chk("txData", {7'b0, txData}, {7'b0, expD});
    @(negedge clk);
    if (inSl && !s) begin
      accM = {accM[6:0], rb};
      if (edgeM == st + 7) rxByteM = accM;
    end
    #1;
    chk("rxValid", {7'b0, rxValid}, {7'b0, (inSl && !s && edgeM == st + 7)});
    chk("rxByte", rxByte, rxByteM);
  endtask

  // a frame of len edges; chg flips select and byte after the sync edge
  task automatic frame(input bit sel, input logic [7:0] b, input logic [7:0] rxb,
                       input int len, input bit chg);
    step(1'b1, sel, b, 1'b0);
    for (int i = 1; i < len; i++) begin
      int st = sel ? 11 : 1;
      bit rb = (i >= st && i < st + 8) ? rxb[7 - (i - st)] : i[0];
      step(1'b0, chg ? ~sel : sel, chg ? ~b : b, rb);
    end
  endtask

  initial begin
    #(5.0 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    // R1: reset state
    #1;
    tag = "R1";
    chk("txEn", {7'b0, txEn}, 8'h0);
    chk("txData", {7'b0, txData}, 8'h0);
    chk("rxValid", {7'b0, rxValid}, 8'h0);
    chk("rxByte", rxByte, 8'h0);
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R2: no slot before the first sync
    tag = "R2";
    for (int i = 0; i < 25; i++) step(1'b0, i[1], 8'hFF, i[0]);

    tag = "R3";
    frame(1'b0, 8'hA5, 8'h3C, 20, 1'b0);
    frame(1'b0, 8'h81, 8'hC3, 12, 1'b0);
    tag = "R4";
    frame(1'b1, 8'h5A, 8'h96, 20, 1'b0);
    frame(1'b1, 8'hFE, 8'h01, 21, 1'b0);
    tag = "R6";
    frame(1'b0, 8'hFF, 8'hFF, 20, 1'b0);
    frame(1'b1, 8'hFF, 8'h7E, 20, 1'b0);
    tag = "R7";
    frame(1'b0, 8'h69, 8'hB4, 20, 1'b1);
    frame(1'b1, 8'h17, 8'hE8, 20, 1'b1);
    tag = "R8";
    frame(1'b0, 8'hC7, 8'h55, 5, 1'b0);
    frame(1'b1, 8'h33, 8'hAA, 14, 1'b0);
    frame(1'b1, 8'h0F, 8'hF0, 11, 1'b0);
    frame(1'b0, 8'h42, 8'h24, 20, 1'b0);
    tag = "R9";
    frame(1'b0, 8'h96, 8'h69, 40, 1'b0);
    frame(1'b1, 8'hE1, 8'h1E, 40, 1'b0);
    tag = "R5";
    frame(1'b0, 8'h00, 8'h80, 20, 1'b0);
    frame(1'b1, 8'h00, 8'h01, 20, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule